// File: doc/BRIEF.md
# Hybrid Prefix Instruction Classifier

This block sorts one 64-bit instruction word pair from a fetch stream into exactly one of eight instruction classes. The encoding mixes 32-bit instructions with 64-bit prefixed forms. Primary opcode 9 carries most of the forms: a plain 32-bit extended-space instruction, scalar forms, single-prefixed forms and vector-prefixed forms. The block decides the class from a small decision tree over a handful of fields. It does not decode the embedded instruction's own fields.

The block also returns the 24-bit prefix field and a flag that is set when that field is all zero. With `OUT_REG` set (the default), every output passes through one register stage, so results appear one clock after the word is presented. With `OUT_REG` cleared, the block is purely combinational.

Bit numbering: bit n is counted from the most significant end of the pair, so bit n is `word_i[63-n]`. The primary opcode is bits 0..5 (`word_i[63:58]`). The prefix field is bits 6..29 (`word_i[57:34]`). The mode pair is bits 30..31 (`word_i[33:32]`, written bit30 first). The vector bit is bit 32 (`word_i[31]`). The sub-opcode is bits 33..37 (`word_i[30:26]`). The tail is bits 62..63 (`word_i[1:0]`). Class flag positions in `cls_o` are:
- 0 plain 32-bit
- 1 opcode-1 prefixed
- 2 32-bit extended (opcode 9)
- 3 scalar upper space
- 4 single-prefixed
- 5 vector-prefixed
- 6 unvectorized 32-bit carried in 64 bits
- 7 reserved

Top module: `hybrid_prefix_classifier`

## Requirements
- R1: For every input value exactly one bit of `cls_o` is set.
- R2: Opcode 1 gives class bit 1. Any opcode other than 1 or 9 gives class bit 0.
- R3: Opcode 9 with mode 00 gives class bit 2.
- R4: Opcode 9 with mode 01 gives class bit 6 when the prefix field is zero, and class bit 4 otherwise.
- R5: Opcode 9 with mode 11 gives class bit 5, whatever the other fields hold.
- R6: Opcode 9, mode 10, vector bit 0 and a sub-opcode other than 10001 gives class bit 3 when the prefix is zero, and class bit 4 otherwise.
- R7: Opcode 9, mode 10, vector bit 1 and a sub-opcode other than 10001 gives class bit 5.
- R8: Opcode 9, mode 10, vector bit 0 and sub-opcode 10001 are classed by the tail. Tail 01 gives bit 5. Tail 00 gives bit 4 with a nonzero prefix and bit 7 with a zero prefix. Tail 10 or 11 gives bit 7.
- R9: Opcode 9, mode 10, vector bit 1 and sub-opcode 10001 gives class bit 7.
- R10: `prefix_o` equals bits 6..29, and `prefix_zero_o` is 1 exactly when that field is zero.
- R11: When the class is bit 0 or bit 2, bits 32..63 (`word_i[31:0]`) have no effect on `cls_o`.
- R12: With `OUT_REG`=1, outputs follow the input one clock later. During reset `cls_o` is 8'h01, `prefix_o` is zero and `prefix_zero_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_i | input | 64 | Instruction word pair, bit 0 at the MSB |
| cls_o | output | 8 | One-hot class flags |
| prefix_o | output | 24 | Prefix field (bits 6..29) |
| prefix_zero_o | output | 1 | Prefix field is all zero |

## Verification
The zero-prefix test and the sub-opcode match against 10001 act on the same word in the same cycle. The tail value and the vector bit interact with them there too. Under opcode 9 with mode 10, these tests decide together between the scalar, single-prefixed, vector-prefixed and reserved classes. A full sweep therefore drives every mix of mode, vector bit, prefix-zero state, sub-opcode match and tail in one word. The non-matching sub-opcode and the nonzero prefix values are varied across the sweep. Each result is judged against a reference function in the bench and checked for a single set flag.

// File: rtl/hpc_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, field positions and class indices for the
// hybrid prefix classifier. Field positions assume bit 0 of the pair is
// word[63] (most-significant-first numbering).
package hpc_pkg;
    localparam int WORD_W  = 64;
    localparam int PO_W    = 6;
    localparam int PFX_W   = 24;
    localparam int SUB_W   = 5;
    localparam int NUM_CLS = 8;

    localparam int PO_LO   = WORD_W - PO_W;          // 58
    localparam int PFX_LO  = PO_LO - PFX_W;          // 34
    localparam int MODE_LO = PFX_LO - 2;             // 32
    localparam int VBIT    = MODE_LO - 1;            // 31
    localparam int SUB_LO  = VBIT - SUB_W;           // 26

    localparam logic [PO_W-1:0]  OPC_PFX   = 6'd1;
    localparam logic [PO_W-1:0]  OPC_HYB   = 6'd9;
    localparam logic [SUB_W-1:0] SUB_MATCH = 5'b10001;

    typedef enum logic [2:0] {
        CLS_PLAIN32 = 3'd0,
        CLS_PFX1    = 3'd1,
        CLS_EXT32   = 3'd2,
        CLS_SCALAR  = 3'd3,
        CLS_SINGLE  = 3'd4,
        CLS_VECTOR  = 3'd5,
        CLS_UNVEC   = 3'd6,
        CLS_RSVD    = 3'd7
    } cls_idx_e;

    typedef struct packed {
        logic [PO_W-1:0]  po;
        logic [PFX_W-1:0] pfx;
        logic [1:0]       mode;
        logic             vbit;
        logic [SUB_W-1:0] sub;
        logic [1:0]       tail;
    } fields_t;
endpackage

// File: rtl/hpc_fields.sv
`timescale 1ns/1ps
// Module: hpc_fields
// Slices the word pair into the fields the class tree needs and reduces
// the prefix field to a zero flag. Pure wiring plus one wide NOR.
// Assumes the package field positions match the word layout.
module hpc_fields
    import hpc_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output fields_t           fld_o,
    output logic              pfx_zero_o
);
    // Field extraction.
    always_comb begin
        fld_o.po   = word_i[WORD_W-1:PO_LO];
        fld_o.pfx  = word_i[PO_LO-1:PFX_LO];
        fld_o.mode = word_i[PFX_LO-1:MODE_LO];
        fld_o.vbit = word_i[VBIT];
        fld_o.sub  = word_i[VBIT-1:SUB_LO];
        fld_o.tail = word_i[1:0];
    end

    // Zero detect on the prefix field.
    assign pfx_zero_o = ~|word_i[PO_LO-1:PFX_LO];
endmodule

// File: rtl/hpc_tree.sv
`timescale 1ns/1ps
// Module: hpc_tree
// Decision tree that maps the extracted fields to a one-hot class vector.
// clk and rst_n serve only the embedded assertions; logic is combinational.
module hpc_tree
    import hpc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  fields_t            fld_i,
    input  logic               pfx_zero_i,
    output logic [NUM_CLS-1:0] cls_o
);
    cls_idx_e idx;
    logic     is_hyb;
    logic     sub_hit;

    assign is_hyb  = (fld_i.po == OPC_HYB);
    assign sub_hit = (fld_i.sub == SUB_MATCH);

    // Class selection by opcode, then mode, then sub-opcode and tail.
    always_comb begin
        if (fld_i.po == OPC_PFX)       idx = CLS_PFX1;
        else if (!is_hyb)              idx = CLS_PLAIN32;
        else begin
            unique case (fld_i.mode)
                2'b00: idx = CLS_EXT32;
                2'b01: idx = pfx_zero_i ? CLS_UNVEC : CLS_SINGLE;
                2'b11: idx = CLS_VECTOR;
                default: begin
                    if (!sub_hit)
                        idx = fld_i.vbit ? CLS_VECTOR
                            : (pfx_zero_i ? CLS_SCALAR : CLS_SINGLE);
                    else if (fld_i.vbit)
                        idx = CLS_RSVD;
                    else begin
                        unique case (fld_i.tail)
                            2'b00:   idx = pfx_zero_i ? CLS_RSVD : CLS_SINGLE;
                            2'b01:   idx = CLS_VECTOR;
                            default: idx = CLS_RSVD;
                        endcase
                    end
                end
            endcase
        end
    end

    // One-hot expansion of the selected index.
    always_comb begin
        cls_o      = '0;
        cls_o[idx] = 1'b1;
    end

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cls_o) == 1);
    p_opc1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_i.po == OPC_PFX) |-> cls_o[CLS_PFX1]);
    p_ext32_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hyb && fld_i.mode == 2'b00) |-> cls_o[CLS_EXT32]);
    p_vec_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hyb && fld_i.mode == 2'b11) |-> cls_o[CLS_VECTOR]);
    p_single_nz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cls_o[CLS_SINGLE] |-> !pfx_zero_i);
    p_vbit_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hyb && fld_i.mode == 2'b10 && fld_i.vbit && sub_hit) |-> cls_o[CLS_RSVD]);
endmodule

// File: rtl/hybrid_prefix_classifier.sv
`timescale 1ns/1ps
// Module: hybrid_prefix_classifier
// Top level: field slicer, class tree and an optional output register.
// OUT_REG=1 adds one cycle of latency; reset is synchronous, active low.
module hybrid_prefix_classifier
    import hpc_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [63:0]        word_i,
    output logic [7:0]         cls_o,
    output logic [23:0]        prefix_o,
    output logic               prefix_zero_o
);
    fields_t            fld;
    logic               pfx_zero;
    logic [NUM_CLS-1:0] cls_c;

    hpc_fields u_fields (
        .word_i     (word_i),
        .fld_o      (fld),
        .pfx_zero_o (pfx_zero)
    );

    hpc_tree u_tree (
        .clk        (clk),
        .rst_n      (rst_n),
        .fld_i      (fld),
        .pfx_zero_i (pfx_zero),
        .cls_o      (cls_c)
    );

    generate
        if (OUT_REG) begin : g_reg
            logic [NUM_CLS-1:0] cls_q;
            logic [PFX_W-1:0]   pfx_q;
            logic               zero_q;

            // Output stage: capture class and prefix, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cls_q  <= NUM_CLS'(1);
                    pfx_q  <= '0;
                    zero_q <= 1'b1;
                end else begin
                    cls_q  <= cls_c;
                    pfx_q  <= fld.pfx;
                    zero_q <= pfx_zero;
                end
            end

            assign cls_o         = cls_q;
            assign prefix_o      = pfx_q;
            assign prefix_zero_o = zero_q;

            p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (cls_o == $past(cls_c)));
            p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
                prefix_zero_o |-> (prefix_o == '0));
        end else begin : g_comb
            assign cls_o         = cls_c;
            assign prefix_o      = fld.pfx;
            assign prefix_zero_o = pfx_zero;
        end
    endgenerate
endmodule

// File: tb/tb_hybrid_prefix_classifier.sv
`timescale 1ns/1ps
module tb_hybrid_prefix_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] word_i = '0;
    logic [7:0]  cls_o;
    logic [23:0] prefix_o;
    logic        prefix_zero_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    hybrid_prefix_classifier dut (
        .clk(clk), .rst_n(rst_n), .word_i(word_i),
        .cls_o(cls_o), .prefix_o(prefix_o), .prefix_zero_o(prefix_zero_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Reference: class index from the requirement text.
    function automatic int ref_cls(input logic [63:0] w);
        logic [5:0] po;
        logic [1:0] md;
        logic       z, vb, hit;
        po  = w[63:58];
        z   = (w[57:34] == 24'd0);
        md  = w[33:32];
        vb  = w[31];
        hit = (w[30:26] == 5'b10001);
        if (po == 6'd1) return 1;
        if (po != 6'd9) return 0;
        if (md == 2'b00) return 2;
        if (md == 2'b01) return z ? 6 : 4;
        if (md == 2'b11) return 5;
        if (!hit) return vb ? 5 : (z ? 3 : 4);
        if (vb) return 7;
        if (w[1:0] == 2'b00) return z ? 7 : 4;
        if (w[1:0] == 2'b01) return 5;
        return 7;
    endfunction

    function automatic logic [63:0] mk(input logic [5:0] po, input logic [23:0] pfx,
                                       input logic [1:0] md, input logic vb,
                                       input logic [4:0] sub, input logic [23:0] mid,
                                       input logic [1:0] tail);
        return {po, pfx, md, vb, sub, mid, tail};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s word=%h actual=%h expected=%h", req, word_i, act, exp);
        end
    endtask

    // Drive at a negedge; registered result is visible at the next negedge.
    task automatic apply(input logic [63:0] w);
        word_i = w;
        @(negedge clk);
    endtask

    task automatic chk_word(input string req, input logic [63:0] w);
        apply(w);
        chk(req, 64'(cls_o), 64'(8'd1 << ref_cls(w)));
        chk("R1", 64'($countones(cls_o)), 64'd1);
    endtask

    task automatic t_reset();
        chk("R12", 64'(cls_o), 64'h01);
        chk("R12", 64'(prefix_o), 64'h0);
        chk("R12", 64'(prefix_zero_o), 64'h1);
    endtask

    task automatic t_opcodes();
        for (int p = 0; p < 64; p++)
            if (p != 9) chk_word("R2", mk(6'(p), 24'hA5C3F1, 2'b10, 1'b1, 5'b10001, 24'h123456, 2'b11));
    endtask

    task automatic t_sweep();
        logic [4:0] miss [3] = '{5'b00000, 5'b11111, 5'b10000};
        for (int m = 0; m < 8; m++)
            for (int z = 0; z < 2; z++)
                for (int h = 0; h < 2; h++)
                    for (int t = 0; t < 4; t++) begin
                        logic [23:0] pf;
                        logic [63:0] w;
                        pf = z ? 24'd0 : (24'h000001 << ((m * 3 + t) % 24));
                        w  = mk(6'd9, pf, 2'(m >> 1), m[0], h ? 5'b10001 : miss[(m + t) % 3],
                                24'h5A5A5A ^ 24'(m * 97 + t), 2'(t));
                        case (m >> 1)
                            0: chk_word("R3", w);
                            1: chk_word("R4", w);
                            3: chk_word("R5", w);
                            default:
                                if (!h) chk_word(m[0] ? "R7" : "R6", w);
                                else    chk_word(m[0] ? "R9" : "R8", w);
                        endcase
                    end
    endtask

    task automatic t_corners();
        apply(mk(6'd9, 24'd0, 2'b10, 1'b0, 5'b10001, 24'd0, 2'b00));
        chk("R8", 64'(cls_o), 64'h80);
        apply(mk(6'd9, 24'h800000, 2'b10, 1'b0, 5'b10001, 24'd0, 2'b00));
        chk("R8", 64'(cls_o), 64'h10);
        apply(mk(6'd9, 24'd0, 2'b01, 1'b1, 5'b10001, 24'hFFFFFF, 2'b11));
        chk("R4", 64'(cls_o), 64'h40);
        apply(mk(6'd9, 24'd0, 2'b10, 1'b0, 5'b00001, 24'd0, 2'b00));
        chk("R6", 64'(cls_o), 64'h08);
    endtask

    task automatic t_prefix();
        logic [23:0] v [4] = '{24'h000000, 24'h000001, 24'h800000, 24'hC0FFEE};
        for (int i = 0; i < 4; i++) begin
            apply(mk(6'd9, v[i], 2'b01, 1'b0, 5'b0, 24'd0, 2'b00));
            chk("R10", 64'(prefix_o), 64'(v[i]));
            chk("R10", 64'(prefix_zero_o), 64'(v[i] == 24'd0));
        end
    endtask

    task automatic t_ignore_upper();
        logic [31:0] up [4] = '{32'h0, 32'hFFFFFFFF, 32'h7C000001, 32'hA5A5A5A5};
        for (int i = 0; i < 4; i++) begin
            apply({6'd9, 24'h3, 2'b00, up[i]});
            chk("R11", 64'(cls_o), 64'h04);
            apply({6'd31, 24'h0, 2'b10, up[i]});
            chk("R11", 64'(cls_o), 64'h01);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        word_i = mk(6'd9, 24'hFFFFFF, 2'b11, 1'b1, 5'b1, 24'h1, 2'b1);
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_opcodes();
        t_sweep();
        t_corners();
        t_prefix();
        t_ignore_upper();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule